// File: doc/BRIEF.md
# ATM Transmit Cell-Rate Filler

This block drives a byte-wide, PHY-facing transmit stream of 53-byte ATM cells. Each cell is a 5-byte header followed by a 48-byte payload. Time on the output is divided into back-to-back cell slots of 53 clock cycles each. At the start of every slot the block decides what the slot carries. If a data cell is waiting at its input, it forwards that cell. RM and OAM cells count as ordinary data cells here.

If no data cell is waiting, the outcome depends on a fill-mode setting. With filler enabled, the block emits an idle cell so that the line rate is kept. With filler disabled, it emits nothing for the slot and holds the active-low transmit enable high.

Data cells arrive over a valid/ready handshake, one byte per clock. A cell that has started always runs to its end. The fill-mode setting and the arrival of new data are looked at only at slot boundaries. Scheduling, shaping, HEC generation and the line interface belong to other blocks.

Top module: `atm_tx_cell_filler`

## Requirements
- R1: While `rst` is high, `tx_en_n` is 1, `tx_sop` is 0, `tx_data` is 0x00 and `in_ready` is 0, whatever the inputs are.
- R2: An idle cell's header bytes, in output order, are 0x00, 0x00, 0x00, 0x01, 0x00. The only bit set is the cell-loss-priority bit, which is bit 0 of the fourth byte.
- R3: All 48 payload bytes of an idle cell are 0x6A.
- R4: A data cell is accepted starting in the first cycle of a slot in which `in_valid` is high. Each accepted byte appears on `tx_data` in the following cycle, in order and unchanged.
- R5: When filler is disabled and no data is waiting at a slot start, `tx_en_n` stays 1 and `tx_sop` stays 0 for all 53 cycles of that slot.
- R6: For every cell that is sent, `tx_en_n` is 0 for all 53 bytes, and `tx_sop` is 1 on the first header byte only. Slots follow one another every 53 cycles with no gap.
- R7: Data that becomes valid in the middle of a slot neither ends the current cell nor is accepted. It is taken at the next slot start.
- R8: A change of `fill_off` in the middle of a slot does not affect that slot. It applies from the next slot start.
- R9: The block registers `fill_off` one cycle before using it, and that register resets to 0. As a result, the first slot after reset is an idle cell even if `fill_off` is 1.
- R10: `in_ready` is 1 only during the 53 cycles of a data cell being forwarded.
- R11: With filler disabled, data cells are still forwarded as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_off | input | 1 | 1 = never send idle cells; 0 = fill empty slots with idle cells |
| in_data | input | 8 | Data-cell byte from the source |
| in_valid | input | 1 | Source has a cell byte available; must stay high for 53 cycles once a cell is accepted |
| in_ready | output | 1 | Byte on `in_data` is taken this cycle |
| tx_data | output | 8 | Transmit byte, registered |
| tx_sop | output | 1 | First header byte of a cell, registered |
| tx_en_n | output | 1 | Transmit enable, active low, registered |

## Verification
A wrong slot counter shows up at the ports within one slot. `tx_sop` then comes early or late relative to the 53-cycle grid, or the enable drops inside a cell. A wrongly latched slot kind is visible from the first output byte of the slot, as an idle header where data was expected or as a deasserted enable. A stale or unregistered fill-mode bit shows up in the first slot after reset or in the slot after a change. The bench checks every byte position of each slot, so a fault in the idle-pattern lookup is reported at the exact byte it affects.

// File: rtl/atm_fill_pkg.sv
`timescale 1ns/1ps
package atm_fill_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_FILL  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/atm_slot_ctrl.sv
`timescale 1ns/1ps
module atm_slot_ctrl
  import atm_fill_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int POS_W      = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             fill_off,
  output logic [POS_W-1:0] pos,
  output slot_kind_e       kind,
  output logic             in_ready
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0] pos_q;
  slot_kind_e       kind_q;
  slot_kind_e       decide;
  logic             fill_off_q;
  logic             boundary;

  assign boundary = (pos_q == '0);

  always_comb begin
    if (in_valid)        decide = SLOT_DATA;
    else if (fill_off_q) decide = SLOT_EMPTY;
    else                 decide = SLOT_FILL;
  end

  assign kind     = boundary ? decide : kind_q;
  assign pos      = pos_q;
  assign in_ready = !rst && (kind == SLOT_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      kind_q     <= SLOT_EMPTY;
      fill_off_q <= 1'b0;
    end else begin
      pos_q      <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      fill_off_q <= fill_off;
      if (boundary) kind_q <= decide;
    end
  end

  // R6: the slot position never leaves the cell
  a_r6_pos_in_cell: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_POS);

  // R7: the slot kind is frozen once a slot is under way
  a_r7_kind_frozen: assert property (@(posedge clk) disable iff (rst)
    (pos_q > POS_W'(1)) |-> $stable(kind_q));

  // R5: filler off and nothing waiting gives an empty slot
  a_r5_empty_slot: assert property (@(posedge clk) disable iff (rst)
    (boundary && fill_off_q && !in_valid) |=> (kind_q == SLOT_EMPTY));
endmodule

// File: rtl/atm_idle_gen.sv
`timescale 1ns/1ps
module atm_idle_gen
  import atm_fill_pkg::*;
#(
  parameter int                    HDR_BYTES = 5,
  parameter int                    POS_W     = 6,
  parameter logic [HDR_BYTES*8-1:0] IDLE_HDR = 40'h00_00_00_01_00,
  parameter logic [BYTE_W-1:0]     IDLE_PAY  = 8'h6A
) (
  input  logic [POS_W-1:0]  pos,
  output logic [BYTE_W-1:0] fill_byte
);
  logic [BYTE_W-1:0] hdr_b [HDR_BYTES];

  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
    assign hdr_b[g] = IDLE_HDR[(HDR_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    fill_byte = IDLE_PAY;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (pos == POS_W'(i)) fill_byte = hdr_b[i];
    end
  end
endmodule

// File: rtl/atm_tx_out_reg.sv
`timescale 1ns/1ps
module atm_tx_out_reg
  import atm_fill_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_kind_e        kind,
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [BYTE_W-1:0] fill_byte,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_en_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data <= '0;
      tx_sop  <= 1'b0;
      tx_en_n <= 1'b1;
    end else begin
      unique case (kind)
        SLOT_DATA: tx_data <= in_data;
        SLOT_FILL: tx_data <= fill_byte;
        default:   tx_data <= '0;
      endcase
      tx_sop  <= (kind != SLOT_EMPTY) && (pos == '0);
      tx_en_n <= (kind == SLOT_EMPTY);
    end
  end

  // R6: a start marker only ever comes with the enable active
  a_r6_sop_enabled: assert property (@(posedge clk) disable iff (rst)
    tx_sop |-> !tx_en_n);

  // R6: two start markers are never adjacent
  a_r6_sop_spacing: assert property (@(posedge clk) disable iff (rst)
    tx_sop |=> !tx_sop);
endmodule

// File: rtl/atm_tx_cell_filler.sv
`timescale 1ns/1ps
module atm_tx_cell_filler
  import atm_fill_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 5,
  parameter logic [HDR_BYTES*8-1:0] IDLE_HDR = 40'h00_00_00_01_00,
  parameter logic [7:0]             IDLE_PAY = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fill_off,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] tx_data,
  output logic       tx_sop,
  output logic       tx_en_n
);
  localparam int POS_W = $clog2(CELL_BYTES);

  logic [POS_W-1:0]  pos;
  slot_kind_e        kind;
  logic [BYTE_W-1:0] fill_byte;

  atm_slot_ctrl #(.CELL_BYTES(CELL_BYTES), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fill_off(fill_off),
    .pos(pos), .kind(kind), .in_ready(in_ready)
  );

  atm_idle_gen #(.HDR_BYTES(HDR_BYTES), .POS_W(POS_W),
                 .IDLE_HDR(IDLE_HDR), .IDLE_PAY(IDLE_PAY)) u_idle (
    .pos(pos), .fill_byte(fill_byte)
  );

  atm_tx_out_reg #(.POS_W(POS_W)) u_out (
    .clk(clk), .rst(rst), .kind(kind), .pos(pos),
    .in_data(in_data), .fill_byte(fill_byte),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_en_n(tx_en_n)
  );

  // R4: an accepted byte is on the output one cycle later
  a_r4_byte_forward: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> (!tx_en_n && tx_data == $past(in_data)));

  // R10: ready only ever leads to an enabled output byte
  a_r10_ready_in_cell: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !tx_en_n);

  // R6: inside a cell the enable does not drop
  a_r6_enable_unbroken: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_n && !tx_sop) |-> $past(!tx_en_n));
endmodule

// File: tb/atm_tx_cell_filler_bench.sv
`timescale 1ns/1ps
module atm_tx_cell_filler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fill_off = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] tx_data;
  logic       tx_sop;
  logic       tx_en_n;

  int n_checks = 0;
  int n_fail   = 0;
  int bcnt     = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  atm_tx_cell_filler u_atm_tx_cell_filler (
    .clk(clk), .rst(rst), .fill_off(fill_off), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_en_n(tx_en_n)
  );

  // slot grid: 53 cycles per slot, first slot starts at the first edge out of reset
  always @(posedge clk) begin
    if (rst) bcnt <= 0;
    else     bcnt <= (bcnt == 52) ? 0 : bcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] idle_byte(input int p);
    if (p < 5) return (p == 3) ? 8'h01 : 8'h00;
    return 8'h6A;
  endfunction

  function automatic logic [7:0] data_byte(input int seed, input int p);
    return 8'(seed + p * 13);
  endfunction

  // kind: 0 empty, 1 data, 2 idle; called at a negedge where bcnt == 0
  task automatic run_slot(input int kind, input bit give, input int seed,
                          input int late, input int fo_at, input bit fo_val,
                          input string tag);
    for (int p = 0; p < 53; p++) begin
      if (p == fo_at) fill_off = fo_val;
      in_valid = give || (late >= 0 && p >= late);
      in_data  = give ? data_byte(seed, p) : 8'hEE;
      #1;
      chk(in_ready == give, tag, $sformatf("in_ready at byte %0d", p), in_ready, give);
      @(negedge clk);
      if (kind == 0) begin
        chk(tx_en_n == 1'b1 && tx_sop == 1'b0, tag,
            $sformatf("empty slot en/sop at byte %0d", p), {tx_en_n, tx_sop}, 2'b10);
      end else begin
        logic [7:0] e;
        e = (kind == 1) ? data_byte(seed, p) : idle_byte(p);
        chk(tx_en_n == 1'b0 && tx_sop == (p == 0) && tx_data == e, tag,
            $sformatf("byte %0d en/sop/data", p),
            {tx_en_n, tx_sop, tx_data}, {1'b0, (p == 0), e});
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; fill_off = 1'b1; in_valid = 1'b1; in_data = 8'h55;
    repeat (4) @(negedge clk);
    // R1: outputs held in their idle state during reset
    chk(tx_en_n == 1'b1, "R1", "tx_en_n in reset", tx_en_n, 1);
    chk(tx_sop == 1'b0, "R1", "tx_sop in reset", tx_sop, 0);
    chk(tx_data == 8'h00, "R1", "tx_data in reset", tx_data, 0);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    run_slot(2, 0, 0, -1, -1, 1'b0, "R9 R2 R3");   // first slot idle though fill_off is 1
    run_slot(0, 0, 0, -1, 10, 1'b0, "R5 R8");      // empty; mid-slot change waits
    run_slot(2, 0, 0, 20, -1, 1'b0, "R7 R2 R3");   // late data does not cut the idle cell
    run_slot(1, 1, 3, -1, -1, 1'b0, "R4 R6 R10");
    run_slot(1, 1, 91, -1, -1, 1'b0, "R4 R6");     // back-to-back data cell
    run_slot(2, 0, 0, -1, 30, 1'b1, "R8 R3");      // idle cell finishes after change to off
    run_slot(1, 1, 170, -1, -1, 1'b1, "R11");
    run_slot(0, 0, 0, -1, -1, 1'b1, "R5 R10");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule